// File: doc/BRIEF.md
# Register-Programmed Raster Timing Generator

This block produces the raster scan for a display pipeline. It counts pixels along a line and lines down a frame, and from those counters it derives the active-display flag, horizontal and vertical sync, and a one-clock prefetch request. The pixel fetch engine uses that request to start loading the next line early. Every geometric position comes from a register that software writes through a simple synchronous write port. Each register holds its position minus one, so the compares run directly on zero-based counters. Sync polarity, blanking, pixel fetch and colour conversion are handled elsewhere.

A two-bit control word is applied at once. Bit 0 runs the scan and bit 1 allows prefetch requests. The nine timing registers are double-buffered: a write lands in a pending copy, and the working copy picks it up only when a frame begins. When software changes timing while the scan runs, the current frame therefore finishes on the old timing and the next frame starts cleanly on the new one.

The scan controller has two states. In OFF the counters are held at zero, every output is low, and the working copy follows the pending copy on every clock. The OFF to RUN transition is taken on the clock after the enable bit is seen set. RUN stays in RUN while enable is set, and its frame-wrap step (last pixel of the last line) reloads the working timing copy. The RUN to OFF transition is taken on the clock after the enable bit is seen clear.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, h_count and v_count are 0, and disp_active, hsync, vsync and prefetch_req are low.
- R2: While running, h_count steps by one per clock from 0 to the horizontal extent register (total pixels minus one) and then returns to 0. v_count advances only on that return, and returns to 0 after the vertical extent value (total lines minus one).
- R3: disp_active is high exactly when h_count is at most the horizontal display register (visible width minus one) and v_count is at most the vertical display register (visible height minus one).
- R4: hsync is high exactly when h_count is greater than the hsync-start register and at most the hsync-end register. With start = width + front porch - 1 and end = start + sync width, the pulse lasts sync-width clocks.
- R5: vsync is high exactly on lines whose v_count is greater than the vsync-start register and at most the vsync-end register.
- R6: When control bit 1 (refresh) is set and the scan runs, prefetch_req is high for the single clock on which h_count equals the prefetch register. The register holds line total minus the prefetch count minus one, and software clamps the count to line total minus one, so the register is never negative. A value of 0 pulses at the start of the line. With bit 1 clear, prefetch_req stays low.
- R7: With control bit 0 (enable) clear, the counters are held at 0 and all four flag outputs are low, whatever bit 1 and the timing registers hold. After enable is written to 1, the first running clock shows h_count = 0 and v_count = 0, one clock after the write edge. The scan stops one clock after enable is written to 0.
- R8: Timing writes made while the scan runs take effect on the first pixel of the next frame. Timing writes made while it is stopped take effect before the scan starts. Control writes take effect on the next clock.
- R9: The address map is: 0 control, 1 horizontal extent, 2 horizontal display, 3 hsync start, 4 hsync end, 5 vertical extent, 6 vertical display, 7 vsync start, 8 vsync end, 9 prefetch position. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register address |
| wr_data | input | DW (12) | Register write data |
| h_count | output | DW (12) | Pixel position within the line |
| v_count | output | DW (12) | Line position within the frame |
| disp_active | output | 1 | Inside the visible area |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| prefetch_req | output | 1 | One-clock request to begin fetching the next line |

## Verification
The assertions assume that the programmed timing is self-consistent. Both extents must exceed the display, sync and prefetch values, and the hsync-end value must not pass the horizontal extent, because the counter-bound and single-pulse checks depend on the working copy never putting a compare point past the wrap point. The stimulus only programs geometries that satisfy those orderings. It changes timing only through the pending copy, either while the scan is stopped or in the middle of a frame, and the frame-boundary and line-advance properties check exactly those two cases.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    // scan controller states
    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } rtg_state_e;

    // control word bit positions
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_REF_BIT = 1;

    // timing register slots; register address = slot + 1, control at 0
    localparam int TI_HEXT  = 0;
    localparam int TI_HDISP = 1;
    localparam int TI_HSS   = 2;
    localparam int TI_HSE   = 3;
    localparam int TI_VEXT  = 4;
    localparam int TI_VDISP = 5;
    localparam int TI_VSS   = 6;
    localparam int TI_VSE   = 7;
    localparam int TI_PF    = 8;
    localparam int NUM_TREG = 9;

endpackage

// File: rtl/rtg_regfile.sv
module rtg_regfile
    import rtg_pkg::*;
#(
    parameter int DW = 12,
    parameter int AW = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [DW-1:0]                 wr_data,
    input  logic                          load_req,
    output logic                          ctrl_en,
    output logic                          ctrl_refresh,
    output logic [NUM_TREG-1:0][DW-1:0]   act_regs
);

    localparam logic [AW-1:0] CTRL_ADDR = '0;

    logic [1:0]                    ctrl_q;
    logic [NUM_TREG-1:0][DW-1:0]   pend_q;

    // control word: applied immediately
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && wr_addr == CTRL_ADDR) begin
            ctrl_q <= wr_data[1:0];
        end
    end

    assign ctrl_en      = ctrl_q[CTRL_EN_BIT];
    assign ctrl_refresh = ctrl_q[CTRL_REF_BIT];

    // pending copy and working copy, one pair per timing register
    for (genvar gi = 0; gi < NUM_TREG; gi++) begin : g_treg
        localparam logic [AW-1:0] SLOT_ADDR = AW'(gi + 1);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[gi] <= '0;
            end else if (wr_en && wr_addr == SLOT_ADDR) begin
                pend_q[gi] <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_regs[gi] <= '0;
            end else if (load_req) begin
                act_regs[gi] <= pend_q[gi];
            end
        end
    end

endmodule

// File: rtl/rtg_scan_fsm.sv
module rtg_scan_fsm
    import rtg_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_en,
    input  logic [DW-1:0] hext,
    input  logic [DW-1:0] vext,
    output logic          run,
    output logic          load_req,
    output logic [DW-1:0] h_cnt,
    output logic [DW-1:0] v_cnt
);

    rtg_state_e state_q, state_d;
    logic       h_wrap, v_wrap;

    assign h_wrap = (h_cnt == hext);
    assign v_wrap = (v_cnt == vext);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: state_d = ctrl_en ? ST_RUN : ST_OFF;
            ST_RUN: state_d = ctrl_en ? ST_RUN : ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // counters advance only while running and still enabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (state_q == ST_RUN && ctrl_en) begin
            if (h_wrap) begin
                h_cnt <= '0;
                v_cnt <= v_wrap ? '0 : v_cnt + DW'(1);
            end else begin
                h_cnt <= h_cnt + DW'(1);
            end
        end else begin
            h_cnt <= '0;
            v_cnt <= '0;
        end
    end

    // outputs of the controller
    always_comb begin
        run      = 1'b0;
        load_req = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                run      = 1'b0;
                load_req = 1'b1;
            end
            ST_RUN: begin
                run      = 1'b1;
                load_req = h_wrap && v_wrap;
            end
            default: begin
                run      = 1'b0;
                load_req = 1'b0;
            end
        endcase
    end

    // R2: line counter returns to zero after the extent
    assert_hwrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ctrl_en && h_wrap) |=> (h_cnt == '0));

    // R2: line counter never passes the extent while running
    assert_hbound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (h_cnt <= hext));

    // R2: line number only moves on a line wrap
    assert_vhold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ctrl_en && !h_wrap) |=> $stable(v_cnt));

endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
    import rtg_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic                        run,
    input  logic                        refresh,
    input  logic [DW-1:0]               h_cnt,
    input  logic [DW-1:0]               v_cnt,
    input  logic [NUM_TREG-1:0][DW-1:0] tregs,
    output logic                        active,
    output logic                        hs,
    output logic                        vs,
    output logic                        pf
);

    logic h_vis, v_vis, h_in_sync, v_in_sync, pf_hit;

    always_comb begin
        h_vis     = (h_cnt <= tregs[TI_HDISP]);
        v_vis     = (v_cnt <= tregs[TI_VDISP]);
        h_in_sync = (h_cnt > tregs[TI_HSS]) && (h_cnt <= tregs[TI_HSE]);
        v_in_sync = (v_cnt > tregs[TI_VSS]) && (v_cnt <= tregs[TI_VSE]);
        pf_hit    = (h_cnt == tregs[TI_PF]);

        active = run && h_vis && v_vis;
        hs     = run && h_in_sync;
        vs     = run && v_in_sync;
        pf     = run && refresh && pf_hit;
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int DW = 12,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] h_count,
    output logic [DW-1:0] v_count,
    output logic          disp_active,
    output logic          hsync,
    output logic          vsync,
    output logic          prefetch_req
);

    logic                        ctrl_en, ctrl_refresh, run, load_req;
    logic [NUM_TREG-1:0][DW-1:0] act_regs;

    rtg_regfile #(.DW(DW), .AW(AW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .load_req     (load_req),
        .ctrl_en      (ctrl_en),
        .ctrl_refresh (ctrl_refresh),
        .act_regs     (act_regs)
    );

    rtg_scan_fsm #(.DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_en  (ctrl_en),
        .hext     (act_regs[TI_HEXT]),
        .vext     (act_regs[TI_VEXT]),
        .run      (run),
        .load_req (load_req),
        .h_cnt    (h_count),
        .v_cnt    (v_count)
    );

    rtg_decode #(.DW(DW)) u_dec (
        .run     (run),
        .refresh (ctrl_refresh),
        .h_cnt   (h_count),
        .v_cnt   (v_count),
        .tregs   (act_regs),
        .active  (disp_active),
        .hs      (hsync),
        .vs      (vsync),
        .pf      (prefetch_req)
    );

    // R7: a stopped scan is silent and parked at the origin
    assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (h_count == '0 && v_count == '0 && !disp_active &&
                  !hsync && !vsync && !prefetch_req));

    // R6: a prefetch request is a single-clock pulse
    assert_pf_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prefetch_req && act_regs[TI_HEXT] != '0 && h_count != act_regs[TI_HEXT])
        |=> !prefetch_req);

    // R8: working timing only changes when a frame begins
    assert_shadow_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !(h_count == '0 && v_count == '0))
        |-> $stable(act_regs));

endmodule

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 12;
    localparam int AW = 4;

    typedef struct {
        int hext; int hdisp; int hss; int hse;
        int vext; int vdisp; int vss; int vse;
        int pf;   bit rf;
    } tp_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] h_count, v_count;
    logic          disp_active, hsync, vsync, prefetch_req;

    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    raster_timing_gen #(.DW(DW), .AW(AW)) i_raster_timing_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .h_count      (h_count),
        .v_count      (v_count),
        .disp_active  (disp_active),
        .hsync        (hsync),
        .vsync        (vsync),
        .prefetch_req (prefetch_req)
    );

    task automatic chk(input string req, input int actual, input int expected);
        nchk++;
        if (actual != expected) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // called at a negedge; the write takes effect at the next posedge
    task automatic write_reg(input int addr, input int data);
        wr_en   = 1'b1;
        wr_addr = AW'(addr);
        wr_data = DW'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic program_timing(input tp_t p);
        write_reg(1, p.hext);  write_reg(2, p.hdisp);
        write_reg(3, p.hss);   write_reg(4, p.hse);
        write_reg(5, p.vext);  write_reg(6, p.vdisp);
        write_reg(7, p.vss);   write_reg(8, p.vse);
        write_reg(9, p.pf);
    endtask

    task automatic check_stopped(input string tag, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            chk({tag, " h_count"}, int'(h_count), 0);
            chk({tag, " v_count"}, int'(v_count), 0);
            chk({tag, " disp_active"}, int'(disp_active), 0);
            chk({tag, " hsync"}, int'(hsync), 0);
            chk({tag, " vsync"}, int'(vsync), 0);
            chk({tag, " prefetch_req"}, int'(prefetch_req), 0);
            @(negedge clk);
        end
    endtask

    // checks cnt clocks starting at position k0 within the frame
    task automatic check_span(input tp_t p, input int k0, input int cnt);
        for (int k = k0; k < k0 + cnt; k++) begin
            int ht, vt, kk, eh, ev;
            ht = p.hext + 1;
            vt = p.vext + 1;
            kk = k % (ht * vt);
            eh = kk % ht;
            ev = kk / ht;
            chk("R2 h_count", int'(h_count), eh);
            chk("R2 v_count", int'(v_count), ev);
            chk("R3 disp_active", int'(disp_active),
                int'(eh <= p.hdisp && ev <= p.vdisp));
            chk("R4 hsync", int'(hsync), int'(eh > p.hss && eh <= p.hse));
            chk("R5 vsync", int'(vsync), int'(ev > p.vss && ev <= p.vse));
            chk("R6 prefetch_req", int'(prefetch_req), int'(p.rf && eh == p.pf));
            @(negedge clk);
        end
    endtask

    tp_t pa, pb, pc;

    task automatic t_reset();
        // R1: state seen right after reset release
        check_stopped("R1", 3);
    endtask

    task automatic t_stopped_program();
        tp_t p0;
        p0 = pa;
        p0.pf = 0;
        program_timing(p0);
        write_reg(0, 2);           // refresh set, enable clear
        check_stopped("R7", 10);   // prefetch at 0 would fire if not gated
        write_reg(9, pa.pf);       // R8: applied while stopped
    endtask

    task automatic t_run_frames();
        write_reg(0, 3);
        @(negedge clk);            // R7: first running clock is at origin
        check_span(pa, 0, 96);
    endtask

    task automatic t_shadow();
        check_span(pa, 0, 10);
        write_reg(1, pb.hext);     // R8: mid-frame write
        check_span(pa, 11, 37);    // current frame keeps old extent
        check_span(pb, 0, 60);     // next frame uses new extent
    endtask

    task automatic t_refresh_off();
        tp_t p;
        p = pb;
        p.rf = 1'b0;
        write_reg(0, 1);           // R6: refresh cleared, still enabled
        check_span(p, 1, 20);
    endtask

    task automatic t_disable();
        write_reg(0, 0);
        @(negedge clk);
        check_stopped("R7", 8);
    endtask

    task automatic t_pf_zero_unmapped();
        write_reg(9, 0);
        write_reg(0, 3);
        @(negedge clk);
        check_span(pc, 0, 30);     // R6: prefetch at line start
        write_reg(12, 12'h001);    // R9: unmapped address
        check_span(pc, 31, 89);
    endtask

    initial begin
        pa = '{hext:7, hdisp:3, hss:4, hse:6, vext:5, vdisp:2, vss:3, vse:4, pf:5, rf:1'b1};
        pb = pa;
        pb.hext = 9;
        pc = pb;
        pc.pf = 0;

        rst_n = 1'b0;
        wr_en = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        t_reset();
        t_stopped_program();
        t_run_frames();
        t_shadow();
        t_refresh_off();
        t_disable();
        t_pf_zero_unmapped();

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule